// File: doc/BRIEF.md
# Edge-Triggered Secondary Interrupt Module

The block collects up to 24 interrupt sources and turns selected edges on them into latched events. Each source passes through a two-flop synchronizer. A per-source 2-bit field then chooses whether its rising edge, its falling edge, both, or neither is an event. Every event is latched into two separate status banks, one for each of two interrupt output lines. Each line has its own mask bank and its own active-low summary output. This lets two independent hosts each service their own view of the same sources.

Software reaches the block through a byte-wide register bus with separate read and write strobes. A control byte chooses how status is cleared. In one mode, a read clears the bits it returned. In the other, software writes 1 to a bit to clear it. The control byte also chooses whether a second event on an already pending source is kept and re-posted once the first is cleared. A test-set register per line lets software post status bits directly.

Top module: `evt_irq_hub`

## Requirements
- R1: A change on `src_in[i]` driven before clock edge k is latched into status at edge k+2. The matching `irq_n` bit, when unmasked, goes low after that same edge and not before.
- R2: Source i owns bits (i mod 4)*2+1 and (i mod 4)*2 of edge byte i/4. The higher bit of the pair enables rising edges and the lower bit enables falling edges. With both bits set, both edges are events. With both bits clear, the source never sets status.
- R3: After reset, every bit of the control and edge-select registers is 0 and every status bit is clear. Every mask bit is 1, and both `irq_n` bits are high.
- R4: An edge event sets the same status bit on both lines. `irq_n[L]` is low exactly while line L has at least one status bit that is set and not masked.
- R5: A mask bit of 1 keeps its status bit off the line's output. It does not stop that status bit from being latched.
- R6: With control bit 0 (clear-on-read) at 0, writing 1 to a status bit clears it, writing 0 leaves it, and reads never clear.
- R7: With control bit 0 at 1, a status read clears exactly the bits it returned, and writes to status have no effect.
- R8: Writing 1 to a test-set bit sets that status bit on that line only. Test-set bits at or above N are ignored, and test-set registers read as 0.
- R9: With control bit 1 (hold) at 1, an event on a source whose status is already set is held. Clearing that bit then leaves it set, so a second clear is needed. With hold at 0, such an event is dropped.
- R10: An edge event in the same cycle as a clear of that status bit wins, and the bit stays set.
- R11: The control byte is at address 0 and the edge bytes start at address 4. Then come, each on the next 4-byte boundary: line 0 status, line 0 mask, line 0 test-set, line 1 status, line 1 mask, line 1 test-set. For N=12 these groups are at 8, 12, 16, 20, 24 and 28. Multi-byte groups are little-endian. Read data appears on `bus_rdata` the cycle after the read strobe and holds until the next read. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Asynchronous interrupt sources |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_rd | input | 1 | Read strobe for one byte |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_n | output | 2 | Active-low summary per line |

## Verification
A source change is applied just after a falling clock edge. Status latches on the third rising edge after that. The bench samples `irq_n` at the falling edges after the second and third rising edges, so it catches both early and late latching. Read data is registered, so every bus read is sampled at the falling edge after the rising edge that captured its strobe. For the same-cycle case, the bench launches a clearing write so that its capturing edge is the edge on which the event latches, and then reads the result back.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef struct packed {
        logic hold;   // bit 1: keep a second event while pending
        logic cor;    // bit 0: reads clear returned status bits
    } evt_ctrl_t;

    typedef enum logic [1:0] {
        GRP_STAT = 2'd0,
        GRP_MASK = 2'd1,
        GRP_TSET = 2'd2
    } evt_grp_e;

    localparam int CTRL_ADDR = 0;
    localparam int EDGE_BASE = 4;
    localparam int GRP_SPAN  = 4;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int align4(input int a);
        return ((a + 3) / 4) * 4;
    endfunction

    // first byte address of a register group for one line
    function automatic int grp_addr(input int n, input int line, input evt_grp_e g);
        return EDGE_BASE + align4(ceil_div(2 * n, 8))
               + line * 3 * GRP_SPAN + int'(g) * GRP_SPAN;
    endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/evt_edge_cfg.sv
module evt_edge_cfg
    import evt_pkg::*;
#(
    parameter int N      = 12,
    parameter int ADDR_W = 6,
    parameter int BASE   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [N-1:0]      rise,
    input  logic [N-1:0]      fall,
    output logic [N-1:0]      ev,
    output logic [7:0]        rd_byte
);
    localparam int EB = ceil_div(2 * N, 8);
    localparam int EW = EB * 8;
    localparam logic [EW-1:0] VALID = EW'((64'd1 << (2 * N)) - 64'd1);

    logic [EW-1:0] sel_q;
    logic [EW-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        for (int b = 0; b < EB; b++) begin
            if (wr && addr == ADDR_W'(BASE + b)) sel_d[b*8 +: 8] = wdata;
        end
        sel_d = sel_d & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign ev[i] = (rise[i] & sel_q[2*i+1]) | (fall[i] & sel_q[2*i]);
    end

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < EB; b++) begin
            if (addr == ADDR_W'(BASE + b)) rd_byte = sel_q[b*8 +: 8];
        end
    end
endmodule

// File: rtl/evt_line_bank.sv
module evt_line_bank
    import evt_pkg::*;
#(
    parameter int N      = 12,
    parameter int ADDR_W = 6,
    parameter int STAT_A = 8,
    parameter int MASK_A = 12,
    parameter int TSET_A = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_ctrl_t         ctrl,
    input  logic [N-1:0]      ev,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_byte,
    output logic              irq_n,
    output logic [N-1:0]      stat_q,
    output logic [N-1:0]      pend_q
);
    logic [N-1:0] mask_q;
    logic [N-1:0] mask_d;
    logic [N-1:0] clr;
    logic [N-1:0] tset;
    logic [N-1:0] hit;
    logic [N-1:0] hold_v;
    logic [N-1:0] stat_d;
    logic [N-1:0] pend_d;

    always_comb begin
        clr    = '0;
        tset   = '0;
        mask_d = mask_q;
        for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(STAT_A + i / 8)) begin
                if (ctrl.cor) clr[i] = rd & stat_q[i];
                else          clr[i] = wr & wdata[3'(i % 8)];
            end
            if (wr && addr == ADDR_W'(TSET_A + i / 8)) tset[i]   = wdata[3'(i % 8)];
            if (wr && addr == ADDR_W'(MASK_A + i / 8)) mask_d[i] = wdata[3'(i % 8)];
        end
    end

    assign hit    = ev | tset;
    assign hold_v = {N{ctrl.hold}};
    // a new event beats a clear; a held event re-posts on clear
    assign stat_d = hit | (stat_q & ~clr) | (pend_q & clr & hold_v);
    assign pend_d = hold_v & ((pend_q & ~clr) | (hit & stat_q & ~clr));

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= stat_d;
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    assign irq_n = ~|(stat_q & ~mask_q);

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(STAT_A + i / 8)) rd_byte[3'(i % 8)] = stat_q[i];
            if (addr == ADDR_W'(MASK_A + i / 8)) rd_byte[3'(i % 8)] = mask_q[i];
        end
    end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_pkg::*;
#(
    parameter int N_SRC  = 12,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        irq_n
);
    localparam int N_LINES = 2;

    evt_ctrl_t        ctrl_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] fall;
    logic [N_SRC-1:0] ev;
    logic [7:0]       edge_rd;
    logic [7:0]       ctrl_rd;
    logic [7:0]       line_rd [N_LINES];
    logic [N_SRC-1:0] stat_all [N_LINES];
    logic [N_SRC-1:0] pend_all [N_LINES];

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= evt_ctrl_t'(bus_wdata[1:0]);
    end

    assign ctrl_rd = (bus_addr == ADDR_W'(CTRL_ADDR)) ? {6'b0, ctrl_q} : 8'h00;

    evt_sync_edge #(.N(N_SRC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .rise   (rise),
        .fall   (fall)
    );

    evt_edge_cfg #(.N(N_SRC), .ADDR_W(ADDR_W), .BASE(EDGE_BASE)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rise    (rise),
        .fall    (fall),
        .ev      (ev),
        .rd_byte (edge_rd)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        evt_line_bank #(
            .N      (N_SRC),
            .ADDR_W (ADDR_W),
            .STAT_A (grp_addr(N_SRC, l, GRP_STAT)),
            .MASK_A (grp_addr(N_SRC, l, GRP_MASK)),
            .TSET_A (grp_addr(N_SRC, l, GRP_TSET))
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl_q),
            .ev      (ev),
            .wr      (bus_wr),
            .rd      (bus_rd),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .rd_byte (line_rd[l]),
            .irq_n   (irq_n[l]),
            .stat_q  (stat_all[l]),
            .pend_q  (pend_all[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= ctrl_rd | edge_rd | line_rd[0] | line_rd[1];
    end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
    parameter int N = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [7:0]   bus_rdata,
    input logic [1:0]   irq_n,
    input logic [N-1:0] stat0,
    input logic [N-1:0] stat1,
    input logic [N-1:0] pend0,
    input logic [N-1:0] pend1
);
    // R3: both outputs idle right after reset
    a_r3_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n == 2'b11)
        else $error("a_r3_idle_after_reset");

    // R4: an asserted line needs a set status bit on that line
    a_r4_low_needs_status: assert property (@(posedge clk) disable iff (rst)
        (!irq_n[0] |-> stat0 != '0) and (!irq_n[1] |-> stat1 != '0))
        else $error("a_r4_low_needs_status");

    // R6: without a bus access no status bit is lost
    a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !bus_rd) |=> ((($past(stat0) & ~stat0) == '0) && (($past(stat1) & ~stat1) == '0)))
        else $error("a_r6_no_silent_clear");

    // R9: a held event only exists behind a set status bit
    a_r9_pend_behind_status: assert property (@(posedge clk) disable iff (rst)
        ((pend0 & ~stat0) == '0) && ((pend1 & ~stat1) == '0))
        else $error("a_r9_pend_behind_status");

    // R11: read data changes only in answer to a read strobe
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata))
        else $error("a_r11_rdata_holds");
endmodule

bind evt_irq_hub evt_irq_hub_chk #(.N(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .stat0     (stat_all[0]),
    .stat1     (stat_all[1]),
    .pend0     (pend_all[0]),
    .pend1     (pend_all[1])
);

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;
    localparam int N  = 12;
    localparam int AW = 6;
    localparam int EB = (2 * N + 7) / 8;
    localparam int C  = 0;
    localparam int E  = 4;
    localparam int S0 = E + ((EB + 3) / 4) * 4;
    localparam int M0 = S0 + 4;
    localparam int T0 = S0 + 8;
    localparam int S1 = S0 + 12;
    localparam int M1 = S0 + 16;
    localparam int T1 = S0 + 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [1:0]    irq_n;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_irq_hub #(.N_SRC(N), .ADDR_W(AW)) u_evt_irq_hub (
        .clk(clk), .rst(rst), .src_in(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bwrite(input int a, input int d);
        bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input int a, output int d);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic rstat(input int base, output int v);
        int lo, hi;
        bread(base, lo);
        bread(base + 1, hi);
        v = lo | (hi << 8);
    endtask

    task automatic clear_all();
        bwrite(S0, 8'hFF); bwrite(S0 + 1, 8'hFF);
        bwrite(S1, 8'hFF); bwrite(S1 + 1, 8'hFF);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int v, v1, x;
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state
        chk("R3 irq_n after reset", int'(irq_n), 3);
        bread(C, v);      chk("R3 control reset", v, 0);
        for (int b = 0; b < EB; b++) begin
            bread(E + b, v); chk("R3 edge reset", v, 0);
        end
        rstat(M0, v);     chk("R3 R11 mask0 reset, unused bits 0", v, 16'h0FFF);
        rstat(M1, v);     chk("R3 mask1 reset", v, 16'h0FFF);
        rstat(S0, v);     chk("R3 status0 reset", v, 0);
        rstat(S1, v);     chk("R3 status1 reset", v, 0);
        bread(40, v);     chk("R11 unmapped reads 0", v, 0);

        // unmask everything on both lines
        bwrite(M0, 0); bwrite(M0 + 1, 0); bwrite(M1, 0); bwrite(M1 + 1, 0);

        // sweep every source through every edge mode
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                int er, ef;
                er = (m >> 1) & 1;
                ef = m & 1;
                for (int b = 0; b < EB; b++)
                    bwrite(E + b, (b == i / 4) ? (m << ((i % 4) * 2)) : 0);
                bread(E + i / 4, v);
                chk("R2 R11 edge field readback", v, m << ((i % 4) * 2));
                src[i] = 1'b1;
                idle(2);
                chk("R1 no latch before third edge", int'(irq_n), 3);
                idle(1);
                chk("R1 R4 irq_n on rising edge", int'(irq_n), er ? 0 : 3);
                rstat(S0, v); rstat(S1, v1);
                chk("R2 R4 line0 rising", v, er << i);
                chk("R2 R4 line1 rising", v1, er << i);
                clear_all();
                src[i] = 1'b0;
                idle(3);
                chk("R1 R4 irq_n on falling edge", int'(irq_n), ef ? 0 : 3);
                rstat(S0, v); rstat(S1, v1);
                chk("R2 R4 line0 falling", v, ef << i);
                chk("R2 R4 line1 falling", v1, ef << i);
                clear_all();
            end
        end

        // masking: line 0 masked, line 1 open
        for (int b = 0; b < EB; b++) bwrite(E + b, 8'hAA);
        bwrite(M0, 8'hFF); bwrite(M0 + 1, 8'hFF);
        src[5] = 1'b1;
        idle(4);
        chk("R5 masked line stays high", int'(irq_n), 2'b01);
        rstat(S0, v);  chk("R5 masked status still latched", v, 1 << 5);
        rstat(S1, v);  chk("R4 line1 latched", v, 1 << 5);
        bwrite(M0, 0); bwrite(M0 + 1, 0);
        chk("R4 R5 unmask asserts line0", int'(irq_n), 0);

        // write-one-to-clear mode
        bread(S0, v);  bread(S0, v);
        chk("R6 reads do not clear", v, 8'h20);
        bwrite(S0, 8'h00);
        bread(S0, v);  chk("R6 writing 0 keeps bit", v, 8'h20);
        bwrite(S0, 8'h20);
        bread(S0, v);  chk("R6 writing 1 clears", v, 0);
        bread(S1, v);  chk("R4 other line untouched", v, 8'h20);
        chk("R4 only line1 asserted", int'(irq_n), 2'b01);

        // clear-on-read mode
        bwrite(C, 1);
        bread(C, v);   chk("R11 control readback", v, 1);
        bread(S1, v);  chk("R7 read returns bit", v, 8'h20);
        bread(S1, v);  chk("R7 read cleared bit", v, 0);
        src[5] = 1'b0; idle(4); src[5] = 1'b1; idle(4);
        bwrite(S0, 8'hFF);
        bread(S0, v);  chk("R7 status write ignored", v, 8'h20);
        bread(S0, v);  chk("R7 second read empty", v, 0);
        bwrite(C, 0);
        clear_all();

        // test-set
        bwrite(T1 + 1, 8'hF8);
        rstat(S1, v);  chk("R8 test-set line1, high bits ignored", v, 1 << 11);
        rstat(S0, v);  chk("R8 other line not set", v, 0);
        bread(T1 + 1, v); chk("R8 test-set reads 0", v, 0);
        chk("R8 test-set drives line1", int'(irq_n), 2'b01);
        bwrite(T0, 8'h81);
        rstat(S0, v);  chk("R8 test-set line0", v, 16'h0081);
        clear_all();
        rstat(S1, v);  chk("R8 cleared", v, 0);

        // hold off: second event dropped
        for (int b = 0; b < EB; b++) bwrite(E + b, 8'hFF);
        src[2] = 1'b1; idle(4); src[2] = 1'b0; idle(4);
        bwrite(S0, 8'h04);
        bread(S0, v);  chk("R9 no hold: one clear empties", v, 0);
        clear_all();

        // hold on: second event re-posts after clear
        bwrite(C, 2);
        src[2] = 1'b1; idle(4); src[2] = 1'b0; idle(4);
        bwrite(S0, 8'h04);
        bread(S0, v);  chk("R9 hold: first clear leaves bit", v, 8'h04);
        bwrite(S0, 8'h04);
        bread(S0, v);  chk("R9 hold: second clear empties", v, 0);
        bwrite(S1, 8'h04);
        bread(S1, v);  chk("R9 hold: line1 keeps its own held event", v, 8'h04);
        bwrite(C, 0);
        clear_all();

        // event in the same cycle as its clear
        src[2] = 1'b1; idle(4);
        bread(S0, v);  chk("R10 bit set before race", v, 8'h04);
        src[2] = 1'b0;
        idle(2);
        bwrite(S0, 8'h04);
        bread(S0, v);  chk("R10 event beats clear", v, 8'h04);
        bread(S1, x);  chk("R10 line1 also set", x, 8'h04);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule